// File: doc/BRIEF.md
# Data-Ready Triggered SPI Sample Reader

This block is an SPI master that reads one complete sample frame from an external converter on every active edge of the converter's data-ready line, with no processor command per sample. The data-ready input is synchronized and edge-detected. An active edge then starts the frame. The block lowers chip select, toggles SCLK from a divided system clock, holds MOSI at zero as a null command, and shifts MISO in MSB first on every rising SCLK edge.

At the end of a frame the block splits the shifted bits into a leading status word and one word per channel. It flags the fault status code and presents the words on a valid/ready output together with a one-cycle done pulse. Triggers that cannot be served set a sticky overrun flag and are dropped.

Parameters select the word width, the number of channels, whether a status word leads the frame, the SCLK half-period in system clocks, the active edge polarity and the fault code. The defaults describe a two-channel frame of three 32-bit words. Setting one 24-bit channel with no status word gives the single-sample variant.

Top module: `readyTriggeredSpiReader`

## Requirements
- R1: After reset, csN is high, sclk is low, mosi is low, and outValid, frameDone, faultFlag and overrun are all low.
- R2: With FALL_EDGE=1, a high-to-low change of readyIn starts a frame after a two-flop synchronizer and an edge detector. A low-to-high change never starts one.
- R3: frameDone rises on exactly the (3 + 2·HALF_DIV·FRAME_BITS + HALF_DIV)-th rising clock edge after readyIn falls. This is edge 389 with the defaults.
- R4: Each frame gives exactly FRAME_BITS rising edges of sclk. sclk is low while csN is high, and each half-period lasts HALF_DIV clocks. csN falls HALF_DIV clocks before the first sclk rise and rises HALF_DIV clocks after the last sclk fall.
- R5: miso is sampled at each rising sclk edge and the first bit is the MSB. The first WORD_W bits form statusWord. The next WORD_W bits form channel 1, which is chanWords[2·WORD_W-1:WORD_W] with the defaults, and the last WORD_W bits form channel 2, which is chanWords[WORD_W-1:0].
- R6: mosi is low in every cycle.
- R7: faultFlag is high with a frame exactly when its statusWord equals FAULT_CODE (default 0x00002220). A status of 0x00002221 gives faultFlag low.
- R8: Once outValid is high, it and the word outputs hold their values until a clock edge with outReady high. outValid is low after that edge.
- R9: An active readyIn edge that arrives while a frame is being read sets overrun. overrun stays high until reset. The frame in progress completes with unchanged data, and no extra frame follows.
- R10: An active readyIn edge that arrives while outValid is high and has not been accepted sets overrun and starts no frame. The held words stay unchanged.
- R11: frameDone is high for a single clock and rises in the same cycle as outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| readyIn | input | 1 | Converter data-ready line, asynchronous |
| sclk | output | 1 | SPI serial clock, idles low |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI master output, held at zero |
| miso | input | 1 | SPI master input |
| outValid | output | 1 | Captured frame available |
| outReady | input | 1 | Consumer accepts the frame |
| statusWord | output | WORD_W | Status word of the held frame |
| chanWords | output | NUM_CHAN·WORD_W | Channel words of the held frame, channel 1 most significant |
| faultFlag | output | 1 | Held status equals the fault code |
| frameDone | output | 1 | One-cycle pulse when a frame is captured |
| overrun | output | 1 | Sticky flag for a dropped trigger |

## Verification
A readyIn change driven at a falling clock edge takes two synchronizer edges plus one detector edge before csN falls. With the defaults, the captured frame, faultFlag and the frameDone pulse therefore appear after edge 389. The bench counts rising edges from the stimulus and samples at each falling edge. It requires frameDone on exactly that count and checks the outputs in that cycle and in the next one. An accept is checked at the falling edge after the single rising edge that consumes it. Dropped triggers are followed for several hundred cycles while the bench counts chip-select falls, to prove that no frame started.

// File: rtl/rtsr_pkg.sv
`timescale 1ns/1ps
package rtsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } rtsrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;  // sample miso at this edge
    logic load;   // move shifted frame to the output register
  } rtsrStrobes_t;

endpackage

// File: rtl/rtsrCtrl.sv
`timescale 1ns/1ps
module rtsrCtrl
  import rtsr_pkg::*;
#(
  parameter int FRAME_BITS = 96,
  parameter int HALF_DIV   = 2,
  parameter bit FALL_EDGE  = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         readyIn,
  input  logic         outValid,
  output logic         sclk,
  output logic         csN,
  output logic         overrun,
  output rtsrStrobes_t strobes
);

  localparam int  HW       = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int  BW       = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic IDLE_LVL = FALL_EDGE;

  // [0],[1] synchronizer, [2] history for the edge detector
  logic [2:0] syncPipe;
  logic       trigger;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= {3{IDLE_LVL}};
    else       syncPipe <= {syncPipe[1:0], readyIn};
  end

  generate
    if (FALL_EDGE) begin : g_fall
      assign trigger = syncPipe[2] & ~syncPipe[1];
    end else begin : g_rise
      assign trigger = ~syncPipe[2] & syncPipe[1];
    end
  endgenerate

  rtsrState_t      state, nextState;
  logic [HW-1:0]   halfCnt;
  logic [BW-1:0]   bitCnt;
  logic            halfEnd, lastBit;

  assign halfEnd = (halfCnt == HW'(HALF_DIV - 1));
  assign lastBit = (bitCnt == BW'(FRAME_BITS - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (trigger && !outValid) nextState = ST_LEAD;
      ST_LEAD: if (halfEnd) nextState = ST_HIGH;
      ST_HIGH: if (halfEnd) nextState = lastBit ? ST_TAIL : ST_LOW;
      ST_LOW:  if (halfEnd) nextState = ST_HIGH;
      ST_TAIL: if (halfEnd) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      overrun <= 1'b0;
    end else begin
      state <= nextState;
      sclk  <= (nextState == ST_HIGH);
      csN   <= (nextState == ST_IDLE);
      if (trigger && (state != ST_IDLE || outValid)) overrun <= 1'b1;
      if (state == ST_IDLE || halfEnd) halfCnt <= '0;
      else                             halfCnt <= halfCnt + 1'b1;
      if (state == ST_IDLE)                       bitCnt <= '0;
      else if (state == ST_HIGH && halfEnd && !lastBit) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shift = halfEnd && (state == ST_LEAD || state == ST_LOW);
    strobes.load  = halfEnd && (state == ST_TAIL);
  end

endmodule

// File: rtl/rtsrPath.sv
`timescale 1ns/1ps
module rtsrPath
  import rtsr_pkg::*;
#(
  parameter int          WORD_W     = 32,
  parameter int          NUM_CHAN   = 2,
  parameter bit          HAS_STATUS = 1'b1,
  parameter logic [63:0] FAULT_CODE = 64'h2220
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rtsrStrobes_t               strobes,
  input  logic                       miso,
  input  logic                       outReady,
  output logic                       outValid,
  output logic [WORD_W-1:0]          statusWord,
  output logic [NUM_CHAN*WORD_W-1:0] chanWords,
  output logic                       faultFlag,
  output logic                       frameDone
);

  localparam int CH_BITS    = NUM_CHAN * WORD_W;
  localparam int FRAME_BITS = CH_BITS + (HAS_STATUS ? WORD_W : 0);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [WORD_W-1:0]     statusNext;
  logic                  faultNext;

  generate
    if (HAS_STATUS) begin : g_status
      assign statusNext = shiftReg[FRAME_BITS-1 -: WORD_W];
      assign faultNext  = (statusNext == FAULT_CODE[WORD_W-1:0]);
    end else begin : g_nostatus
      assign statusNext = '0;
      assign faultNext  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      outValid   <= 1'b0;
      statusWord <= '0;
      chanWords  <= '0;
      faultFlag  <= 1'b0;
      frameDone  <= 1'b0;
    end else begin
      frameDone <= strobes.load;
      if (strobes.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], miso};
      if (strobes.load) begin
        outValid   <= 1'b1;
        statusWord <= statusNext;
        chanWords  <= shiftReg[CH_BITS-1:0];
        faultFlag  <= faultNext;
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/readyTriggeredSpiReader.sv
`timescale 1ns/1ps
module readyTriggeredSpiReader
  import rtsr_pkg::*;
#(
  parameter int          WORD_W     = 32,
  parameter int          NUM_CHAN   = 2,
  parameter bit          HAS_STATUS = 1'b1,
  parameter int          HALF_DIV   = 2,
  parameter bit          FALL_EDGE  = 1'b1,
  parameter logic [63:0] FAULT_CODE = 64'h2220
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       readyIn,
  output logic                       sclk,
  output logic                       csN,
  output logic                       mosi,
  input  logic                       miso,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [WORD_W-1:0]          statusWord,
  output logic [NUM_CHAN*WORD_W-1:0] chanWords,
  output logic                       faultFlag,
  output logic                       frameDone,
  output logic                       overrun
);

  localparam int FRAME_BITS = (NUM_CHAN + (HAS_STATUS ? 1 : 0)) * WORD_W;

  rtsrStrobes_t strobes;

  assign mosi = 1'b0;  // null command during reads

  rtsrCtrl #(
    .FRAME_BITS(FRAME_BITS),
    .HALF_DIV  (HALF_DIV),
    .FALL_EDGE (FALL_EDGE)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .readyIn (readyIn),
    .outValid(outValid),
    .sclk    (sclk),
    .csN     (csN),
    .overrun (overrun),
    .strobes (strobes)
  );

  rtsrPath #(
    .WORD_W    (WORD_W),
    .NUM_CHAN  (NUM_CHAN),
    .HAS_STATUS(HAS_STATUS),
    .FAULT_CODE(FAULT_CODE)
  ) path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .miso      (miso),
    .outReady  (outReady),
    .outValid  (outValid),
    .statusWord(statusWord),
    .chanWords (chanWords),
    .faultFlag (faultFlag),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/rtsrChecker.sv
`timescale 1ns/1ps
module rtsrChecker #(
  parameter int          WORD_W     = 32,
  parameter int          NUM_CHAN   = 2,
  parameter bit          HAS_STATUS = 1'b1,
  parameter logic [63:0] FAULT_CODE = 64'h2220
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sclk,
  input logic                       csN,
  input logic                       outValid,
  input logic                       outReady,
  input logic [WORD_W-1:0]          statusWord,
  input logic [NUM_CHAN*WORD_W-1:0] chanWords,
  input logic                       faultFlag,
  input logic                       frameDone,
  input logic                       overrun
);

  // R4: the serial clock only toggles inside chip select
  a_r4_sclk_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  // R4: chip select releases only with sclk low
  a_r4_cs_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !sclk);

  // R8: held frame is stable until accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(statusWord) && $stable(chanWords) && $stable(faultFlag)));

  // R7: fault flag agrees with the held status word
  a_r7_fault_code: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (faultFlag == ((HAS_STATUS != 1'b0) && (statusWord == FAULT_CODE[WORD_W-1:0]))));

  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R11: done is a single-cycle pulse, aligned with valid rising
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  a_r11_done_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> frameDone);

endmodule

bind readyTriggeredSpiReader rtsrChecker #(
  .WORD_W    (WORD_W),
  .NUM_CHAN  (NUM_CHAN),
  .HAS_STATUS(HAS_STATUS),
  .FAULT_CODE(FAULT_CODE)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclk      (sclk),
  .csN       (csN),
  .outValid  (outValid),
  .outReady  (outReady),
  .statusWord(statusWord),
  .chanWords (chanWords),
  .faultFlag (faultFlag),
  .frameDone (frameDone),
  .overrun   (overrun)
);

// File: tb/readyTriggeredSpiReader_test.sv
`timescale 1ns/1ps
module readyTriggeredSpiReader_test;

  localparam int WORD_W = 32;
  localparam int NUM_CHAN = 2;
  localparam int HALF = 2;
  localparam int FB = (NUM_CHAN + 1) * WORD_W;
  localparam int LAT = 3 + 2 * HALF * FB + HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readyIn = 1'b1;
  logic miso = 1'b0;
  logic outReady = 1'b0;
  logic sclk, csN, mosi, outValid, faultFlag, frameDone, overrun;
  logic [WORD_W-1:0] statusWord;
  logic [NUM_CHAN*WORD_W-1:0] chanWords;

  always #2.5 clk = ~clk;

  readyTriggeredSpiReader uut (
    .clk(clk), .rstN(rstN), .readyIn(readyIn), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso), .outValid(outValid), .outReady(outReady),
    .statusWord(statusWord), .chanWords(chanWords), .faultFlag(faultFlag),
    .frameDone(frameDone), .overrun(overrun)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // converter model: MSB first, next bit after each falling sclk
  logic [FB-1:0] slaveFrame = '0;
  int slaveIdx = 0;
  always @(negedge csN) begin
    slaveIdx = FB - 1;
    miso = slaveFrame[slaveIdx];
  end
  always @(negedge sclk) begin
    if (csN === 1'b0 && slaveIdx > 0) begin
      slaveIdx = slaveIdx - 1;
      miso = slaveFrame[slaveIdx];
    end
  end

  // bus monitors
  int sclkRises = 0;
  int badRises = 0;
  int mosiBad = 0;
  int csFalls = 0;
  always @(posedge sclk) begin
    sclkRises++;
    if (csN !== 1'b0) badRises++;
  end
  always @(negedge csN) csFalls++;
  always @(negedge clk) if (rstN && mosi !== 1'b0) mosiBad++;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    readyIn = 1'b1;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drops readyIn at a falling clock edge and counts rising edges to frameDone
  task automatic startAndWait(output int lat);
    @(negedge clk);
    readyIn = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!frameDone && lat < 4 * LAT);
  endtask

  task automatic accept(input string req);
    @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(req, outValid, 1'b0);
  endtask

  task automatic testReset();
    doReset();
    check("R1 csN", csN, 1'b1);
    check("R1 sclk", sclk, 1'b0);
    check("R1 mosi", mosi, 1'b0);
    check("R1 outputs", {outValid, frameDone, faultFlag, overrun}, 4'b0000);
  endtask

  task automatic testFrame(input logic [FB-1:0] f, input logic expFault, input string tag);
    int lat;
    int fallsBefore;
    slaveFrame = f;
    sclkRises = 0;
    badRises = 0;
    fallsBefore = csFalls;
    startAndWait(lat);
    check({"R3 latency ", tag}, lat, LAT);
    check({"R11 valid with done ", tag}, outValid, 1'b1);
    check({"R5 status ", tag}, statusWord, f[FB-1 -: WORD_W]);
    check({"R5 channels ", tag}, chanWords, f[NUM_CHAN*WORD_W-1:0]);
    check({"R7 fault ", tag}, faultFlag, expFault);
    check({"R4 sclk rises ", tag}, sclkRises, FB);
    check({"R4 sclk inside cs ", tag}, badRises, 0);
    @(negedge clk);
    check({"R11 done width ", tag}, frameDone, 1'b0);
    readyIn = 1'b1;  // rising edge: no frame
    accept({"R8 accept ", tag});
    repeat (20) @(negedge clk);
    check({"R2 rising edge ignored ", tag}, csFalls - fallsBefore, 1);
    check({"R2 cs idle ", tag}, csN, 1'b1);
  endtask

  task automatic testHold();
    int lat;
    logic [FB-1:0] f;
    f = {32'h0000_0042, 32'hDEAD_BEEF, 32'h1357_9BDF};
    slaveFrame = f;
    startAndWait(lat);
    readyIn = 1'b1;
    repeat (25) @(negedge clk);
    check("R8 valid held", outValid, 1'b1);
    check("R8 channels held", chanWords, f[63:0]);
    check("R8 status held", statusWord, f[95:64]);
    accept("R8 cleared after accept");
  endtask

  task automatic testBlockedByValid();
    int lat;
    int fallsBefore;
    logic [FB-1:0] f;
    doReset();
    f = {32'h0000_0007, 32'h0102_0304, 32'hF0E0_D0C0};
    slaveFrame = f;
    startAndWait(lat);
    readyIn = 1'b1;
    fallsBefore = csFalls;
    repeat (5) @(negedge clk);
    slaveFrame = ~f;
    readyIn = 1'b0;  // trigger while frame unaccepted
    repeat (2 * LAT) @(negedge clk);
    check("R10 overrun set", overrun, 1'b1);
    check("R10 no frame started", csFalls - fallsBefore, 0);
    check("R10 data unchanged", chanWords, f[63:0]);
    readyIn = 1'b1;
    accept("R10 accept");
  endtask

  task automatic testOverrun();
    int lat;
    int fallsBefore;
    logic [FB-1:0] f;
    doReset();
    check("R9 overrun clear after reset", overrun, 1'b0);
    f = {32'h0000_0099, 32'h7FFF_FFFF, 32'h8000_0000};
    slaveFrame = f;
    fallsBefore = csFalls;
    @(negedge clk);
    readyIn = 1'b0;
    lat = 0;
    while (!frameDone && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
      if (lat == 100) readyIn = 1'b1;
      if (lat == 106) readyIn = 1'b0;  // second trigger during the read
    end
    check("R9 latency unchanged", lat, LAT);
    check("R9 overrun set", overrun, 1'b1);
    check("R9 frame intact", {statusWord, chanWords}, f);
    readyIn = 1'b1;
    accept("R9 accept");
    repeat (2 * LAT) @(negedge clk);
    check("R9 no extra frame", csFalls - fallsBefore, 1);
    check("R9 overrun sticky", overrun, 1'b1);
  endtask

  initial begin
    testReset();
    testFrame({32'h0000_1234, 32'hA5A5_0F0F, 32'h8000_0001}, 1'b0, "plain");
    testFrame({32'h0000_2220, 32'h0000_0000, 32'hFFFF_FFFF}, 1'b1, "fault");
    testFrame({32'h0000_2221, 32'h5555_AAAA, 32'h0F0F_F0F0}, 1'b0, "near fault");
    testHold();
    testBlockedByValid();
    testOverrun();
    check("R6 mosi low", mosiBad, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule